// File: doc/BRIEF.md
# Half-Bridge PWM Driver with Fault Latch

This block turns a period and duty setting into two identical complementary half-bridge drives, four pins in all. Pins A and C are the high-side drives, active while the period counter is below the duty value. Pins B and D are the low-side drives, active for the rest of the period. A dead band, counted in instruction cycles of four clocks each, delays every turn-on edge so that neither switch of a bridge conducts until its partner has been off for the programmed time. Turn-off edges are never delayed.

Three fault sources can be enabled in any combination: two comparator trip levels and an active-low fault pin. An enabled fault forces the pins into programmable safe states at once, through a path that uses no clock. A synchronized copy of the fault sets a status flag, which keeps the pins in their safe states. The flag is released either automatically or by an explicit clear request, depending on the restart setting. A clear request has no effect while the fault is still present. Once the flag is released, the pins stay safe until the next period boundary and then resume.

Top module: `pwm_hb_top`

## Requirements
- R1: Pins A and C carry the same high-side drive and pins B and D carry the same low-side drive. A high-side pin and a low-side pin are never both high in the same cycle.
- R2: In the source select, bit 0 enables comparator 1 (trip when high), bit 1 enables comparator 2 (trip when high), and bit 2 enables the fault pin (trip when low). With select 000, no input level causes a shutdown and the status flag stays clear.
- R3: An enabled trip forces all four pins to their safe states without waiting for a clock edge.
- R4: Safe-state codes are 00 for drive low, 01 for drive high, and 10 or 11 for tri-state (enable low, value 0). The A/C code applies to pins 0 and 2, and the B/D code applies to pins 1 and 3. The status flag is set no later than the third rising edge after an enabled trip, and the pins stay safe while the flag is set.
- R5: A delay value d postpones every turn-on edge by 4·d clocks and leaves turn-off edges immediate. Each side is therefore active for its natural width minus 4·d clocks in every period.
- R6: With delay 0 there is no dead band. The high side is active for exactly `duty` clocks of each `period`+1-clock period, and the low side is active for all the remaining clocks.
- R7: If 4·d is not less than a pulse's natural width, that output stays low for the whole pulse.
- R8: A clear request while the synchronized trip is still active leaves the status flag set.
- R9: With restart 0, the flag stays set after the trip goes away until a clear request arrives. With restart 1, the flag clears by itself once the trip goes away.
- R10: After the flag clears, the pins stay in their safe states until the next period start. Normal output then resumes from the first clock of that period.
- R11: During reset and right after it, all pins are driven low with their enables high and the status flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period | input | 8 | Last counter value of a period (length period+1) |
| duty | input | 8 | High-side active clocks per period |
| dly_cnt | input | 7 | Dead band in 4-clock units |
| src_sel | input | 3 | Fault source enables (bit0 cmp1, bit1 cmp2, bit2 fault pin) |
| cmp1_trip | input | 1 | Comparator 1 trip level, active high |
| cmp2_trip | input | 1 | Comparator 2 trip level, active high |
| fault_n | input | 1 | Fault pin, active low |
| safe_ac | input | 2 | Safe-state code for pins A and C |
| safe_bd | input | 2 | Safe-state code for pins B and D |
| auto_restart | input | 1 | 1: flag clears automatically after the trip goes away |
| flag_clr | input | 1 | Clear request for the status flag |
| pin_out | output | 4 | Pin values {D,C,B,A} |
| pin_oe | output | 4 | Pin output enables {D,C,B,A} |
| shut_flag | output | 1 | Shutdown status flag |

## Verification
The hardest case to reach from the ports is the wait for a period boundary after the flag clears, because the period counter is not visible. The bench sets delay 0 and chooses safe codes that no normal cycle can produce. It then waits for the first non-safe sample and requires that the high side opens there and stays high for exactly `duty` clocks, which can only happen at a period start. The clock-free override is checked by changing a comparator level between edges and sampling before the next edge. The blocked clear request is checked by pulsing it while the trip is still held.

// File: rtl/pwm_hb_pkg.sv
`timescale 1ns/1ps
package pwm_hb_pkg;
  typedef enum logic [1:0] {
    SAFE_LOW  = 2'b00,
    SAFE_HIGH = 2'b01,
    SAFE_OFFA = 2'b10,
    SAFE_OFFB = 2'b11
  } safe_code_e;

  localparam int NUM_PINS  = 4;
  localparam int NUM_SIDES = 2;
  localparam int NUM_SRC   = 3;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             start_o,
  output logic             raw_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q >= period_i) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign start_o = (cnt_q == '0);
  assign raw_o   = (cnt_q < duty_i);
endmodule

// File: rtl/pwm_deadband.sv
`timescale 1ns/1ps
module pwm_deadband #(
  parameter int DLY_W    = 7,
  parameter int TCY_CLKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             out_o
);
  localparam int CW = DLY_W + $clog2(TCY_CLKS) + 1;

  logic [CW-1:0] dly_clks;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done;

  assign dly_clks = CW'(dly_i) * CW'(TCY_CLKS);
  assign done     = (cnt_q >= dly_clks);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!in_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign out_o = in_i & done;

  // R5
  dly_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_o) && (dly_i != '0)) |-> $past(in_i));
endmodule

// File: rtl/pwm_fault_latch.sv
`timescale 1ns/1ps
module pwm_fault_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp1_i,
  input  logic       cmp2_i,
  input  logic       fault_n_i,
  input  logic [2:0] src_sel_i,
  input  logic       auto_restart_i,
  input  logic       flag_clr_i,
  input  logic       period_start_i,
  output logic       force_o,
  output logic       flag_o
);
  logic [2:0]             src_vec;
  logic                   trip_raw;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   trip_sync;
  logic                   flag_q, flag_d;
  logic                   hold_q, hold_d;

  assign src_vec  = {~fault_n_i, cmp2_i, cmp1_i};
  assign trip_raw = |(src_sel_i & src_vec);

  assign sync_d    = {sync_q[SYNC_STAGES-2:0], trip_raw};
  assign trip_sync = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (trip_sync)                         flag_d = 1'b1;
    else if (auto_restart_i || flag_clr_i) flag_d = 1'b0;
    else                                   flag_d = flag_q;
  end

  always_comb begin
    if (flag_q)              hold_d = 1'b1;
    else if (period_start_i) hold_d = 1'b0;
    else                     hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      flag_q <= flag_d;
      hold_q <= hold_d;
    end
  end

  assign force_o = trip_raw | flag_q | (hold_q & ~period_start_i);
  assign flag_o  = flag_q;

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_sync |=> flag_q);
  // R8
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && trip_sync && flag_clr_i) |=> flag_q);
  // R9
  manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !auto_restart_i && !flag_clr_i) |=> flag_q);
  // R10
  resume_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flag_q) && !period_start_i) |-> force_o);
endmodule

// File: rtl/pwm_hb_top.sv
`timescale 1ns/1ps
module pwm_hb_top
  import pwm_hb_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int DLY_W       = 7,
  parameter int TCY_CLKS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  input  logic [DLY_W-1:0] dly_cnt,
  input  logic [2:0]       src_sel,
  input  logic             cmp1_trip,
  input  logic             cmp2_trip,
  input  logic             fault_n,
  input  logic [1:0]       safe_ac,
  input  logic [1:0]       safe_bd,
  input  logic             auto_restart,
  input  logic             flag_clr,
  output logic [3:0]       pin_out,
  output logic [3:0]       pin_oe,
  output logic             shut_flag
);
  logic [1:0]           rst_q;
  logic                 rst_n_s;
  logic                 start, raw, force_safe;
  logic [NUM_SIDES-1:0] side_in, side_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n_s), .period_i(period), .duty_i(duty),
    .start_o(start), .raw_o(raw)
  );

  pwm_fault_latch #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
    .clk(clk), .rst_n(rst_n_s), .cmp1_i(cmp1_trip), .cmp2_i(cmp2_trip),
    .fault_n_i(fault_n), .src_sel_i(src_sel), .auto_restart_i(auto_restart),
    .flag_clr_i(flag_clr), .period_start_i(start),
    .force_o(force_safe), .flag_o(shut_flag)
  );

  // side 0 = high side, side 1 = low side
  assign side_in[0] = raw  & ~force_safe;
  assign side_in[1] = ~raw & ~force_safe;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    pwm_deadband #(.DLY_W(DLY_W), .TCY_CLKS(TCY_CLKS)) u_db (
      .clk(clk), .rst_n(rst_n_s), .in_i(side_in[s]), .dly_i(dly_cnt),
      .out_o(side_out[s])
    );
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    safe_code_e code;
    logic       drive;
    assign code  = safe_code_e'((p % 2 == 0) ? safe_ac : safe_bd);
    assign drive = side_out[p % 2];
    always_comb begin
      if (!rst_n_s) begin
        pin_out[p] = 1'b0;
        pin_oe[p]  = 1'b1;
      end else if (force_safe) begin
        pin_out[p] = (code == SAFE_HIGH);
        pin_oe[p]  = (code == SAFE_LOW) || (code == SAFE_HIGH);
      end else begin
        pin_out[p] = drive;
        pin_oe[p]  = 1'b1;
      end
    end
  end

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(side_out[0] && side_out[1]));
endmodule

// File: tb/sim_pwm_hb_top.sv
`timescale 1ns/1ps
module sim_pwm_hb_top;
  localparam int PERIOD_V = 19;
  localparam int DUTY_V   = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] period, duty;
  logic [6:0] dly_cnt;
  logic [2:0] src_sel;
  logic       cmp1_trip, cmp2_trip, fault_n;
  logic [1:0] safe_ac, safe_bd;
  logic       auto_restart, flag_clr;
  logic [3:0] pin_out, pin_oe;
  logic       shut_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pwm_hb_top u0 (
    .clk(clk), .rst_n(rst_n), .period(period), .duty(duty), .dly_cnt(dly_cnt),
    .src_sel(src_sel), .cmp1_trip(cmp1_trip), .cmp2_trip(cmp2_trip),
    .fault_n(fault_n), .safe_ac(safe_ac), .safe_bd(safe_bd),
    .auto_restart(auto_restart), .flag_clr(flag_clr),
    .pin_out(pin_out), .pin_oe(pin_oe), .shut_flag(shut_flag)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic measure(output int a_cnt, output int b_cnt,
                         output int overlap, output int mism);
    a_cnt = 0; b_cnt = 0; overlap = 0; mism = 0;
    for (int i = 0; i < PERIOD_V + 1; i++) begin
      tick();
      a_cnt += int'(pin_out[0]);
      b_cnt += int'(pin_out[1]);
      if (pin_out[0] && pin_out[1]) overlap++;
      if (pin_out[2] != pin_out[0] || pin_out[3] != pin_out[1]) mism++;
    end
  endtask

  // wait for first non-safe sample, then measure the high-side run length
  task automatic resume_run(input bit use_oe, output int first_a, output int run);
    int guard = 0;
    while (guard < 40 && (use_oe ? (pin_oe != 4'hF) : !(pin_out[0] | pin_out[1]))) begin
      tick();
      guard++;
    end
    first_a = int'(pin_out[0]);
    run = 0;
    while (run < 40 && pin_out[0]) begin
      run++;
      tick();
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    period = 8'(PERIOD_V); duty = 8'(DUTY_V); dly_cnt = '0; src_sel = '0;
    cmp1_trip = 0; cmp2_trip = 0; fault_n = 1; safe_ac = 2'b00; safe_bd = 2'b00;
    auto_restart = 0; flag_clr = 0;
    tick(); tick();
    chk(pin_out == 4'h0, "R11", "pins in reset", int'(pin_out), 0);
    chk(pin_oe == 4'hF, "R11", "enables in reset", int'(pin_oe), 15);
    chk(shut_flag == 1'b0, "R11", "flag in reset", int'(shut_flag), 0);
    rst_n = 1'b1;
    tick();
    chk(pin_out == 4'h0 && shut_flag == 1'b0, "R11", "pins after release",
        int'(pin_out), 0);
  endtask

  task automatic t_no_dead_band();
    int a, b, ov, mm;
    dly_cnt = 7'd0;
    repeat (40) tick();
    measure(a, b, ov, mm);
    chk(a == DUTY_V, "R6", "high-side clocks", a, DUTY_V);
    chk(b == PERIOD_V + 1 - DUTY_V, "R6", "low-side clocks", b, PERIOD_V + 1 - DUTY_V);
    chk(ov == 0, "R1", "overlap clocks", ov, 0);
    chk(mm == 0, "R1", "pair copies differ", mm, 0);
  endtask

  task automatic t_dead_band();
    int a, b, ov, mm;
    dly_cnt = 7'd1;
    repeat (40) tick();
    measure(a, b, ov, mm);
    chk(a == DUTY_V - 4, "R5", "high-side clocks", a, DUTY_V - 4);
    chk(b == PERIOD_V + 1 - DUTY_V - 4, "R5", "low-side clocks", b, PERIOD_V + 1 - DUTY_V - 4);
    chk(ov == 0, "R1", "overlap with dead band", ov, 0);
  endtask

  task automatic t_long_dead_band();
    int a, b, ov, mm;
    dly_cnt = 7'd3;
    repeat (40) tick();
    measure(a, b, ov, mm);
    chk(a == 0, "R7", "high side under long delay", a, 0);
    chk(b == 0, "R7", "low side under long delay", b, 0);
    dly_cnt = 7'd0;
  endtask

  task automatic t_no_source();
    int a, b, ov, mm;
    src_sel = 3'b000; cmp1_trip = 1; cmp2_trip = 1; fault_n = 0;
    repeat (5) tick();
    measure(a, b, ov, mm);
    chk(a == DUTY_V, "R2", "output with sources disabled", a, DUTY_V);
    chk(shut_flag == 1'b0, "R2", "flag with sources disabled", int'(shut_flag), 0);
    cmp1_trip = 0; cmp2_trip = 0; fault_n = 1;
    repeat (5) tick();
  endtask

  task automatic t_async_and_manual();
    int first_a, run;
    safe_ac = 2'b01; safe_bd = 2'b10; src_sel = 3'b001; auto_restart = 0;
    tick();
    cmp1_trip = 1;
    #1;
    chk(pin_out == 4'b0101, "R3", "pins before any edge", int'(pin_out), 5);
    chk(pin_oe == 4'b0101, "R4", "enables under tri-state code", int'(pin_oe), 5);
    tick(); tick(); tick();
    chk(shut_flag == 1'b1, "R4", "flag after three edges", int'(shut_flag), 1);
    flag_clr = 1; tick(); flag_clr = 0; tick();
    chk(shut_flag == 1'b1, "R8", "flag after blocked clear", int'(shut_flag), 1);
    cmp1_trip = 0;
    repeat (6) tick();
    chk(shut_flag == 1'b1, "R9", "flag without restart", int'(shut_flag), 1);
    chk(pin_out == 4'b0101 && pin_oe == 4'b0101, "R4", "pins held by flag",
        int'(pin_out), 5);
    flag_clr = 1; tick(); flag_clr = 0;
    chk(shut_flag == 1'b0, "R9", "flag after clear", int'(shut_flag), 0);
    resume_run(1'b1, first_a, run);
    chk(first_a == 1, "R10", "high side at resume", first_a, 1);
    chk(run == DUTY_V, "R10", "first pulse width after resume", run, DUTY_V);
  endtask

  task automatic t_auto_restart();
    int first_a, run;
    safe_ac = 2'b00; safe_bd = 2'b00; src_sel = 3'b010; auto_restart = 1;
    tick();
    cmp2_trip = 1;
    #1;
    chk(pin_out == 4'h0 && pin_oe == 4'hF, "R3", "cmp2 drives pins low at once",
        int'(pin_out), 0);
    cmp2_trip = 0;
    src_sel = 3'b100;
    fault_n = 0;
    repeat (4) tick();
    chk(shut_flag == 1'b1, "R2", "flag from fault pin", int'(shut_flag), 1);
    fault_n = 1;
    repeat (5) tick();
    chk(shut_flag == 1'b0, "R9", "flag after auto restart", int'(shut_flag), 0);
    resume_run(1'b0, first_a, run);
    chk(first_a == 1, "R10", "high side at auto resume", first_a, 1);
    chk(run == DUTY_V, "R10", "pulse width after auto resume", run, DUTY_V);
  endtask

  initial begin
    t_reset();
    t_no_dead_band();
    t_dead_band();
    t_long_dead_band();
    t_no_source();
    t_async_and_manual();
    t_auto_restart();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule